// File: doc/BRIEF.md
# Configurable Output Cell for a Sum-of-Products Logic Array

This block is one output cell of a programmable sum-of-products logic device. The AND and OR arrays outside the cell produce its inputs: a data sum term for the register (D, or J), a second sum term (K), a separate combinatorial sum term for the pin, and per-cell product terms. These product terms cover flip-flop mode, load, preset, reset, clock and output enable. The cell also sees a shared external clock pin, a shared active-low external enable pin, and the level present on its own pad.

Static configuration inputs set the following:
- whether the register may switch to J-K behaviour or is fixed as a D flip-flop;
- whether the register is clocked from the external pin or from its own product-term clock;
- where the output enable comes from;
- whether the pad shows the inverted register or a combinatorial path with selectable polarity.

In the combinatorial configuration the register does not disappear. It becomes a buried register with its own inputs and its own feedback into the array. In every configuration, a disabled pad can be sampled into the register through the load term.

Top module: `sop_out_cell`

## Requirements
- R1: While `rst_ni` is low the register output `reg_fb_o` is 0, and clock edges do not change it.
- R2: When `fc_term_i` is low, or `cfg_d_only_i` is high, each rising edge of the selected clock loads `jd_sum_i` into the register.
- R3: When `fc_term_i` is high and `cfg_d_only_i` is low, a rising edge acts as a J-K flip-flop with J=`jd_sum_i` and K=`k_sum_i`:
  - 00 holds;
  - 01 clears;
  - 10 sets;
  - 11 inverts.
- R4: With `cfg_pt_clk_i` low the register is clocked by `ext_clk_i`. With it high it is clocked by `pt_clk_i`, and edges on the unselected clock have no effect.
- R5: With `cfg_comb_i` high, `pad_o` equals `comb_sum_i` XOR `cfg_invert_i`, while the register keeps updating from its own sum terms.
- R6: With `cfg_comb_i` low, `pad_o` is the inverse of the register output, and `cfg_invert_i` has no effect.
- R7: The enable source follows `cfg_oe_sel_i`:
  - 2'b00 enables when `ext_oe_ni` is low;
  - 2'b01 enables when `oe_term_i` is high;
  - 2'b10 and 2'b11 always enable.
- R8: When `load_term_i` is high and `pad_oe_o` is low, a clock edge loads `pad_i` into the register and the sum terms are ignored. When the pad is enabled, the load term has no effect.
- R9: `preset_term_i` sets and `reset_term_i` clears the register at once, without a clock edge. When both are high the register is 1.
- R10: `comb_fb_o` follows the level on `pad_i`, and `reg_fb_o` follows the register, in both configurations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low power-up reset, clears the register |
| ext_clk_i | input | 1 | Shared external clock pin |
| ext_oe_ni | input | 1 | Shared active-low external enable pin |
| pt_clk_i | input | 1 | Cell product-term clock |
| jd_sum_i | input | 1 | Register sum term, D or J |
| k_sum_i | input | 1 | Register sum term K |
| fc_term_i | input | 1 | Flip-flop mode term, high selects J-K |
| comb_sum_i | input | 1 | Sum term for the combinatorial pin path |
| load_term_i | input | 1 | Load-from-pad product term |
| preset_term_i | input | 1 | Asynchronous preset product term |
| reset_term_i | input | 1 | Asynchronous reset product term |
| oe_term_i | input | 1 | Active-high enable product term |
| pad_i | input | 1 | Level seen on the pad |
| cfg_d_only_i | input | 1 | Fix register as D type |
| cfg_pt_clk_i | input | 1 | Select product-term clock |
| cfg_oe_sel_i | input | 2 | Enable source select |
| cfg_comb_i | input | 1 | Combinatorial pad with buried register |
| cfg_invert_i | input | 1 | Polarity of the combinatorial path |
| pad_o | output | 1 | Pad drive value |
| pad_oe_o | output | 1 | Pad driver enable |
| comb_fb_o | output | 1 | Pad feedback into the array |
| reg_fb_o | output | 1 | Register feedback into the array |

## Verification
Several register functions can act in the same cycle, and the bench provokes each overlap on purpose.
- A clock edge can arrive while the load term is high. The bench raises the load term with a data sum term that would produce the opposite value. It then judges at the edge whether the pad level or the sum term won, for the pad disabled and for it enabled.
- Preset and reset can be held together while the clock runs. The bench checks that the register reads 1. It then drops only the preset and checks that the register falls to 0 without waiting for an edge.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;
  localparam int OE_SEL_W = 2;
  localparam logic [OE_SEL_W-1:0] OE_FROM_PIN  = 2'b00;
  localparam logic [OE_SEL_W-1:0] OE_FROM_TERM = 2'b01;

  typedef enum logic [1:0] {
    JK_HOLD   = 2'b00,
    JK_CLEAR  = 2'b01,
    JK_SET    = 2'b10,
    JK_INVERT = 2'b11
  } jk_code_e;
endpackage

// File: rtl/sop_cell_next.sv
module sop_cell_next
  import sop_cell_pkg::*;
(
  input  logic jd_i,
  input  logic k_i,
  input  logic jk_mode_i,
  input  logic preload_i,
  input  logic pin_i,
  input  logic q_i,
  output logic d_o
);
  jk_code_e jk;
  assign jk = jk_code_e'({jd_i, k_i});

  always_comb begin
    if (preload_i) begin
      d_o = pin_i;
    end else if (jk_mode_i) begin
      unique case (jk)
        JK_HOLD:   d_o = q_i;
        JK_CLEAR:  d_o = 1'b0;
        JK_SET:    d_o = 1'b1;
        JK_INVERT: d_o = ~q_i;
        default:   d_o = q_i;
      endcase
    end else begin
      d_o = jd_i;
    end
  end
endmodule

// File: rtl/sop_cell_oe.sv
module sop_cell_oe
  import sop_cell_pkg::*;
(
  input  logic [OE_SEL_W-1:0] sel_i,
  input  logic                pin_oe_ni,
  input  logic                term_oe_i,
  output logic                oe_o
);
  always_comb begin
    unique case (sel_i)
      OE_FROM_PIN:  oe_o = ~pin_oe_ni;
      OE_FROM_TERM: oe_o = term_oe_i;
      default:      oe_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sop_cell_ff.sv
module sop_cell_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  // clear only counts when set is absent, so dropping set under a held clear re-triggers
  logic clr_eff;
  assign clr_eff = clr_i & ~set_i;

  always_ff @(posedge clk_i or negedge rst_ni or posedge set_i or posedge clr_eff) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (set_i)   q_o <= 1'b1;
    else if (clr_eff) q_o <= 1'b0;
    else              q_o <= d_i;
  end

  a_r9_preset_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> q_o);
  a_r9_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |-> !q_o);
endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
  import sop_cell_pkg::*;
(
  input  logic                rst_ni,
  input  logic                ext_clk_i,
  input  logic                ext_oe_ni,
  input  logic                pt_clk_i,
  input  logic                jd_sum_i,
  input  logic                k_sum_i,
  input  logic                fc_term_i,
  input  logic                comb_sum_i,
  input  logic                load_term_i,
  input  logic                preset_term_i,
  input  logic                reset_term_i,
  input  logic                oe_term_i,
  input  logic                pad_i,
  input  logic                cfg_d_only_i,
  input  logic                cfg_pt_clk_i,
  input  logic [OE_SEL_W-1:0] cfg_oe_sel_i,
  input  logic                cfg_comb_i,
  input  logic                cfg_invert_i,
  output logic                pad_o,
  output logic                pad_oe_o,
  output logic                comb_fb_o,
  output logic                reg_fb_o
);
  logic cell_clk;
  logic jk_mode;
  logic preload;
  logic d_next;
  logic q;

  assign cell_clk = cfg_pt_clk_i ? pt_clk_i : ext_clk_i;
  assign jk_mode  = fc_term_i & ~cfg_d_only_i;
  assign preload  = load_term_i & ~pad_oe_o;

  sop_cell_oe u_oe (
    .sel_i     (cfg_oe_sel_i),
    .pin_oe_ni (ext_oe_ni),
    .term_oe_i (oe_term_i),
    .oe_o      (pad_oe_o)
  );

  sop_cell_next u_next (
    .jd_i      (jd_sum_i),
    .k_i       (k_sum_i),
    .jk_mode_i (jk_mode),
    .preload_i (preload),
    .pin_i     (pad_i),
    .q_i       (q),
    .d_o       (d_next)
  );

  sop_cell_ff u_ff (
    .clk_i  (cell_clk),
    .rst_ni (rst_ni),
    .set_i  (preset_term_i),
    .clr_i  (reset_term_i),
    .d_i    (d_next),
    .q_o    (q)
  );

  assign pad_o     = cfg_comb_i ? (comb_sum_i ^ cfg_invert_i) : ~q;
  assign comb_fb_o = pad_i;
  assign reg_fb_o  = q;

  a_r3_jk_invert: assert property (@(posedge cell_clk)
    disable iff (!rst_ni || preset_term_i || reset_term_i)
    $past(rst_ni && fc_term_i && !cfg_d_only_i && jd_sum_i && k_sum_i && !load_term_i
          && !preset_term_i && !reset_term_i)
    |-> (reg_fb_o != $past(reg_fb_o)));

  a_r8_preload: assert property (@(posedge cell_clk)
    disable iff (!rst_ni || preset_term_i || reset_term_i)
    $past(rst_ni && load_term_i && !pad_oe_o && !preset_term_i && !reset_term_i)
    |-> (reg_fb_o == $past(pad_i)));

  a_r6_regout_inverted: assert property (@(posedge cell_clk) disable iff (!rst_ni)
    !cfg_comb_i |-> (pad_o != reg_fb_o));

  a_r7_always_on: assert property (@(posedge cell_clk) disable iff (!rst_ni)
    cfg_oe_sel_i[1] |-> pad_oe_o);
endmodule

// File: tb/sop_out_cell_bench.sv
module sop_out_cell_bench;
  logic rst_ni = 1'b0, ext_clk = 1'b0, ext_oe_n = 1'b1, pt_clk = 1'b0;
  logic jd = 1'b0, k = 1'b0, fc = 1'b0, comb_sum = 1'b0;
  logic load = 1'b0, preset = 1'b0, reset = 1'b0, oe_term = 1'b0, pad_in = 1'b0;
  logic cfg_d_only = 1'b0, cfg_pt_clk = 1'b0, cfg_comb = 1'b0, cfg_invert = 1'b0;
  logic [1:0] cfg_oe_sel = 2'b10;
  logic pad_o, pad_oe, comb_fb, reg_fb;
  int checks = 0, fails = 0;

  always #2.5 ext_clk = ~ext_clk;

  sop_out_cell u_sop_out_cell (
    .rst_ni(rst_ni), .ext_clk_i(ext_clk), .ext_oe_ni(ext_oe_n), .pt_clk_i(pt_clk),
    .jd_sum_i(jd), .k_sum_i(k), .fc_term_i(fc), .comb_sum_i(comb_sum),
    .load_term_i(load), .preset_term_i(preset), .reset_term_i(reset),
    .oe_term_i(oe_term), .pad_i(pad_in), .cfg_d_only_i(cfg_d_only),
    .cfg_pt_clk_i(cfg_pt_clk), .cfg_oe_sel_i(cfg_oe_sel), .cfg_comb_i(cfg_comb),
    .cfg_invert_i(cfg_invert), .pad_o(pad_o), .pad_oe_o(pad_oe),
    .comb_fb_o(comb_fb), .reg_fb_o(reg_fb)
  );

  // {fc, d_only, j/d, k, expected q after one edge}; starts from q=0
  localparam logic [4:0] VEC [12] = '{
    5'b00101, 5'b00010, 5'b10101, 5'b10001, 5'b10110, 5'b10111,
    5'b10010, 5'b10000, 5'b11111, 5'b11000, 5'b00111, 5'b10010
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic edge_wait();
    @(negedge ext_clk);
  endtask

  initial begin
    repeat (20000) @(posedge ext_clk);
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset holds register at 0 despite clock and D=1
    jd = 1'b1;
    repeat (3) edge_wait();
    chk("R1 reset", reg_fb, 1'b0);
    jd = 1'b0;
    rst_ni = 1'b1;
    edge_wait();
    chk("R1 after release", reg_fb, 1'b0);

    // R2/R3/R6 table walk, registered output, invert set to show it is ignored
    cfg_comb = 1'b0; cfg_invert = 1'b1; cfg_oe_sel = 2'b10;
    for (int i = 0; i < 12; i++) begin
      {fc, cfg_d_only, jd, k} = VEC[i][4:1];
      edge_wait();
      chk(VEC[i][4] && !VEC[i][3] ? "R3 jk" : "R2 d", reg_fb, VEC[i][0]);
      chk("R6 pad inverted", pad_o, ~VEC[i][0]);
    end
    fc = 1'b0; cfg_d_only = 1'b0; jd = 1'b0; k = 1'b0;
    edge_wait();

    // R5: combinatorial pad, buried register still runs
    cfg_comb = 1'b1; cfg_invert = 1'b0; comb_sum = 1'b1; jd = 1'b1;
    #1 chk("R5 comb true", pad_o, 1'b1);
    cfg_invert = 1'b1;
    #1 chk("R5 comb inverted", pad_o, 1'b0);
    edge_wait();
    chk("R5 buried reg loads", reg_fb, 1'b1);
    comb_sum = 1'b0; jd = 1'b0;
    edge_wait();
    chk("R5 buried reg", reg_fb, 1'b0);
    chk("R5 comb low inv", pad_o, 1'b1);

    // R7: enable sources
    cfg_oe_sel = 2'b00; ext_oe_n = 1'b0;
    #1 chk("R7 pin low", pad_oe, 1'b1);
    ext_oe_n = 1'b1;
    #1 chk("R7 pin high", pad_oe, 1'b0);
    cfg_oe_sel = 2'b01; oe_term = 1'b1;
    #1 chk("R7 term high", pad_oe, 1'b1);
    oe_term = 1'b0;
    #1 chk("R7 term low", pad_oe, 1'b0);
    cfg_oe_sel = 2'b11;
    #1 chk("R7 always 11", pad_oe, 1'b1);
    cfg_oe_sel = 2'b10;
    #1 chk("R7 always 10", pad_oe, 1'b1);

    // R10: pad feedback
    pad_in = 1'b1;
    #1 chk("R10 pad fb", comb_fb, 1'b1);
    pad_in = 1'b0;
    #1 chk("R10 pad fb low", comb_fb, 1'b0);
    edge_wait();

    // R8: preload with pad disabled beats D=0
    cfg_comb = 1'b0; cfg_oe_sel = 2'b00; ext_oe_n = 1'b1;
    load = 1'b1; pad_in = 1'b1; jd = 1'b0;
    edge_wait();
    chk("R8 preload 1", reg_fb, 1'b1);
    pad_in = 1'b0; jd = 1'b1; fc = 1'b1; k = 1'b0;
    edge_wait();
    chk("R8 preload 0 over set", reg_fb, 1'b0);
    fc = 1'b0;
    ext_oe_n = 1'b0; pad_in = 1'b1; jd = 1'b0;
    edge_wait();
    chk("R8 load ignored when enabled", reg_fb, 1'b0);
    load = 1'b0; ext_oe_n = 1'b1; pad_in = 1'b0;
    edge_wait();

    // R4: product-term clock selected, external edges ignored
    cfg_pt_clk = 1'b1; jd = 1'b1;
    repeat (3) edge_wait();
    chk("R4 ext ignored", reg_fb, 1'b0);
    pt_clk = 1'b1;
    #1 chk("R4 pt clock", reg_fb, 1'b1);
    pt_clk = 1'b0;
    jd = 1'b0;
    #1 chk("R4 pt falling", reg_fb, 1'b1);
    edge_wait();
    cfg_pt_clk = 1'b0;
    edge_wait();
    chk("R4 back to ext", reg_fb, 1'b0);

    // R9: asynchronous preset/reset
    preset = 1'b1;
    #1 chk("R9 preset", reg_fb, 1'b1);
    reset = 1'b1;
    #1 chk("R9 both", reg_fb, 1'b1);
    edge_wait();
    chk("R9 both over clock", reg_fb, 1'b1);
    preset = 1'b0;
    #1 chk("R9 reset after preset drop", reg_fb, 1'b0);
    reset = 1'b0; jd = 1'b1;
    edge_wait();
    chk("R2 resume", reg_fb, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule